// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block holds the per-channel transfer registers of a DMA controller. Each channel has a 16-bit base address, a 16-bit base count, a current address and a running transfer position. Software programs the bank one byte at a time over an 8-bit port. A single byte-pointer flop, shared by all channels, chooses whether an access goes to the low byte or the high byte. Every channel access flips that pointer. The control block can force it back to the low byte.

Writing the high byte of either base register restarts the channel. The current address is loaded from the base address, scaled for word mode, and the transfer position returns to zero. The channel service engine reads the current address, the position and the transfer length from dedicated outputs, and writes new positions back. A read of the address port returns the live address, which moves up or down with the position depending on the channel's direction. A read of the count port returns the remaining count. The `WORD_MODE` parameter scales addresses and counts by two for a 16-bit controller.

Top module: `dmab_chan_bank`

## Requirements
- R1: Reset clears the byte pointer to 0 (low byte) and clears every base address, base count, current address and position to zero.
- R2: Each clock cycle with `wr_en_i` or `rd_en_i` high inverts `byte_hi_o` at that edge. Reads and writes count the same way and the channel does not matter. Without an access, clear or control reset, the pointer holds its value.
- R3: When `ff_clear_i` or `ctl_reset_i` is high, `byte_hi_o` is 0 after that edge, even if an access happens in the same cycle.
- R4: A write with `byte_hi_o`=0 replaces bits 7:0 of the selected base register only. It changes no current address, no position and no other register.
- R5: A write with `byte_hi_o`=1 replaces bits 15:8 of the selected base register. In the same edge it sets that channel's current address to base address << SHIFT and its position to 0.
- R6: A read of an address port returns the current address plus the position (direction bit 0), or the current address minus the position (direction bit 1), taken in two's complement.
- R7: A read of a count port returns (base count << SHIFT) − position, in two's complement.
- R8: `pos_we_i` loads `pos_val_i` into the position of channel `pos_chan_i` at the next edge. A re-initialising high-byte write to the same channel in the same cycle wins and leaves the position at 0.
- R9: The port index is `bus_off_i >> SHIFT`. Index bits [2:1] select the channel. Index bit 0 selects the register: 0 is the address, 1 is the count.
- R10: `xfer_len_o` for each channel equals (base count + 1) << SHIFT. For example, a base count of 0xFFFF gives 0x10000 at SHIFT=0.
- R11: The read byte is bits [SHIFT+7:SHIFT] of the R6/R7 value when `byte_hi_o`=0, and bits [SHIFT+15:SHIFT+8] when it is 1. It is available in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_off_i | input | 3+SHIFT | Channel port offset on the bus |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| wr_data_i | input | 8 | Write byte |
| rd_data_o | output | 8 | Read byte for the selected port and pointer |
| ff_clear_i | input | 1 | Force pointer to low byte (from control block) |
| ctl_reset_i | input | 1 | Controller soft reset, also clears the pointer |
| dir_down_i | input | NUM_CH | Per-channel address direction, 1 = decrement |
| pos_we_i | input | 1 | Engine position write enable |
| pos_chan_i | input | 2 | Channel for the position write |
| pos_val_i | input | 17+SHIFT | New position value |
| byte_hi_o | output | 1 | Byte pointer state |
| cur_addr_o | output | NUM_CH*(16+SHIFT) | Current addresses, channel 0 in the low slice |
| pos_o | output | NUM_CH*(17+SHIFT) | Transfer positions |
| xfer_len_o | output | NUM_CH*(17+SHIFT) | Transfer lengths (base count + 1) scaled |

## Verification
Read data is combinational, so the bench samples `rd_data_o` two nanoseconds after it drives the strobe at the falling edge. This happens before the rising edge that flips the pointer. Register effects (pointer flip or clear, base byte update, re-initialisation, position load) all land at the one rising edge that ends the access cycle. The bench therefore checks `byte_hi_o`, `cur_addr_o`, `pos_o` and `xfer_len_o` one nanosecond after that edge. It compares them with a byte-level model that it updates in the same order as R8 and R5 settle a collision.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
  // register selected by index bit 0 of a channel port
  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } dmab_sel_e;
endpackage

// File: rtl/dmab_ptr_flop.sv
module dmab_ptr_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic access_i,
  input  logic clear_i,
  output logic hi_o
);
  logic hi_d;

  always_comb begin
    hi_d = hi_o;
    if (clear_i)       hi_d = 1'b0;
    else if (access_i) hi_d = ~hi_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_o <= 1'b0;
    else        hi_o <= hi_d;
  end
endmodule

// File: rtl/dmab_chan_regs.sv
module dmab_chan_regs
  import dmab_pkg::*;
#(
  parameter int SHIFT = 0,
  localparam int AW = 16 + SHIFT,
  localparam int PW = 17 + SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  dmab_sel_e     sel_i,
  input  logic          hi_i,
  input  logic [7:0]    data_i,
  input  logic          pos_we_i,
  input  logic [PW-1:0] pos_i,
  output logic [15:0]   base_cnt_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [PW-1:0] pos_o
);
  logic [15:0]   base_addr_q, base_addr_d, base_cnt_d;
  logic [AW-1:0] cur_d;
  logic [PW-1:0] pos_d;

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_o;
    cur_d       = cur_addr_o;
    pos_d       = pos_o;
    if (wr_en_i) begin
      if (sel_i == SEL_CNT) begin
        if (hi_i) base_cnt_d[15:8] = data_i;
        else      base_cnt_d[7:0]  = data_i;
      end else begin
        if (hi_i) base_addr_d[15:8] = data_i;
        else      base_addr_d[7:0]  = data_i;
      end
    end
    if (pos_we_i) pos_d = pos_i;
    // high byte write restarts the channel, overriding the engine
    if (wr_en_i && hi_i) begin
      cur_d = AW'(base_addr_d) << SHIFT;
      pos_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_o  <= '0;
      cur_addr_o  <= '0;
      pos_o       <= '0;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_o  <= base_cnt_d;
      cur_addr_o  <= cur_d;
      pos_o       <= pos_d;
    end
  end
endmodule

// File: rtl/dmab_rd_mux.sv
module dmab_rd_mux
  import dmab_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SHIFT  = 0,
  localparam int AW  = 16 + SHIFT,
  localparam int PW  = 17 + SHIFT,
  localparam int RW  = PW + 1,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic [NUM_CH*AW-1:0] cur_flat_i,
  input  logic [NUM_CH*PW-1:0] pos_flat_i,
  input  logic [NUM_CH*16-1:0] cnt_flat_i,
  input  logic [NUM_CH-1:0]    dir_down_i,
  input  logic [CHW-1:0]       chan_i,
  input  dmab_sel_e            sel_i,
  input  logic                 hi_i,
  output logic [7:0]           byte_o
);
  logic [AW-1:0] cur;
  logic [PW-1:0] pos;
  logic [15:0]   cnt;
  logic [RW-1:0] addr_val, cnt_val, pick, shifted;
  logic [4:0]    sh_amt;

  always_comb begin
    cur      = cur_flat_i[chan_i*AW +: AW];
    pos      = pos_flat_i[chan_i*PW +: PW];
    cnt      = cnt_flat_i[chan_i*16 +: 16];
    addr_val = dir_down_i[chan_i] ? (RW'(cur) - RW'(pos)) : (RW'(cur) + RW'(pos));
    cnt_val  = (RW'(cnt) << SHIFT) - RW'(pos);
    pick     = (sel_i == SEL_CNT) ? cnt_val : addr_val;
    sh_amt   = hi_i ? 5'(SHIFT + 8) : 5'(SHIFT);
    shifted  = pick >> sh_amt;
    byte_o   = shifted[7:0];
  end
endmodule

// File: rtl/dmab_chan_bank.sv
module dmab_chan_bank
  import dmab_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int WORD_MODE = 0,
  localparam int SHIFT = (WORD_MODE != 0) ? 1 : 0,
  localparam int AW    = 16 + SHIFT,
  localparam int PW    = 17 + SHIFT,
  localparam int CHW   = $clog2(NUM_CH),
  localparam int OFFW  = CHW + 1 + SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OFFW-1:0]      bus_off_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [7:0]           wr_data_i,
  output logic [7:0]           rd_data_o,
  input  logic                 ff_clear_i,
  input  logic                 ctl_reset_i,
  input  logic [NUM_CH-1:0]    dir_down_i,
  input  logic                 pos_we_i,
  input  logic [CHW-1:0]       pos_chan_i,
  input  logic [PW-1:0]        pos_val_i,
  output logic                 byte_hi_o,
  output logic [NUM_CH*AW-1:0] cur_addr_o,
  output logic [NUM_CH*PW-1:0] pos_o,
  output logic [NUM_CH*PW-1:0] xfer_len_o
);
  logic [OFFW-1:0]      port_idx;
  logic [CHW-1:0]       chan;
  dmab_sel_e            sel;
  logic [NUM_CH*16-1:0] cnt_flat;

  always_comb begin
    port_idx = bus_off_i >> SHIFT;
    chan     = port_idx[CHW:1];
    sel      = dmab_sel_e'(port_idx[0]);
  end

  dmab_ptr_flop u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .access_i (wr_en_i | rd_en_i),
    .clear_i  (ff_clear_i | ctl_reset_i),
    .hi_o     (byte_hi_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [15:0] cnt_q;
    dmab_chan_regs #(.SHIFT(SHIFT)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i && (chan == CHW'(c))),
      .sel_i      (sel),
      .hi_i       (byte_hi_o),
      .data_i     (wr_data_i),
      .pos_we_i   (pos_we_i && (pos_chan_i == CHW'(c))),
      .pos_i      (pos_val_i),
      .base_cnt_o (cnt_q),
      .cur_addr_o (cur_addr_o[c*AW +: AW]),
      .pos_o      (pos_o[c*PW +: PW])
    );
    assign cnt_flat[c*16 +: 16]   = cnt_q;
    assign xfer_len_o[c*PW +: PW] = (PW'(cnt_q) + PW'(1)) << SHIFT;
  end

  dmab_rd_mux #(.NUM_CH(NUM_CH), .SHIFT(SHIFT)) u_rd (
    .cur_flat_i (cur_addr_o),
    .pos_flat_i (pos_o),
    .cnt_flat_i (cnt_flat),
    .dir_down_i (dir_down_i),
    .chan_i     (chan),
    .sel_i      (sel),
    .hi_i       (byte_hi_o),
    .byte_o     (rd_data_o)
  );
endmodule

// File: rtl/dmab_chan_bank_chk.sv
module dmab_chan_bank_chk #(
  parameter int NUM_CH    = 4,
  parameter int WORD_MODE = 0,
  localparam int SHIFT = (WORD_MODE != 0) ? 1 : 0,
  localparam int AW    = 16 + SHIFT,
  localparam int PW    = 17 + SHIFT,
  localparam int CHW   = $clog2(NUM_CH),
  localparam int OFFW  = CHW + 1 + SHIFT
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [OFFW-1:0]      bus_off_i,
  input logic                 wr_en_i,
  input logic                 rd_en_i,
  input logic                 ff_clear_i,
  input logic                 ctl_reset_i,
  input logic                 pos_we_i,
  input logic [CHW-1:0]       pos_chan_i,
  input logic [PW-1:0]        pos_val_i,
  input logic                 byte_hi_o,
  input logic [NUM_CH*AW-1:0] cur_addr_o,
  input logic [NUM_CH*PW-1:0] pos_o
);
  logic [OFFW-1:0] idx;
  logic [CHW-1:0]  acc_ch;
  logic            clr;
  assign idx    = bus_off_i >> SHIFT;
  assign acc_ch = idx[CHW:1];
  assign clr    = ff_clear_i | ctl_reset_i;

  always @(posedge clk)
    if (!rst_n) assert_reset_ptr_R1: assert (byte_hi_o == 1'b0);

  assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en_i || rd_en_i) && !clr) |=> (byte_hi_o != $past(byte_hi_o)));

  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !rd_en_i && !clr) |=> $stable(byte_hi_o));

  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !byte_hi_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_reinit_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && byte_hi_o && acc_ch == CHW'(c)) |=> (pos_o[c*PW +: PW] == '0));

    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && byte_hi_o && acc_ch == CHW'(c)) |=> $stable(cur_addr_o[c*AW +: AW]));

    assert_pos_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_we_i && pos_chan_i == CHW'(c) && !(wr_en_i && byte_hi_o && acc_ch == CHW'(c)))
      |=> (pos_o[c*PW +: PW] == $past(pos_val_i)));
  end
endmodule

bind dmab_chan_bank dmab_chan_bank_chk #(.NUM_CH(NUM_CH), .WORD_MODE(WORD_MODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_off_i   (bus_off_i),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .ff_clear_i  (ff_clear_i),
  .ctl_reset_i (ctl_reset_i),
  .pos_we_i    (pos_we_i),
  .pos_chan_i  (pos_chan_i),
  .pos_val_i   (pos_val_i),
  .byte_hi_o   (byte_hi_o),
  .cur_addr_o  (cur_addr_o),
  .pos_o       (pos_o)
);

// File: tb/dmab_chan_bank_bench.sv
module dmab_chan_bank_bench;
  localparam int NCH = 4;
  localparam int SH  = 0;
  localparam int AW  = 16;
  localparam int PW  = 17;

  logic clk, rst_n;
  logic [2:0] bus_off_i;
  logic wr_en_i, rd_en_i, ff_clear_i, ctl_reset_i, pos_we_i;
  logic [7:0] wr_data_i, rd_data_o;
  logic [NCH-1:0] dir_down_i;
  logic [1:0] pos_chan_i;
  logic [PW-1:0] pos_val_i;
  logic byte_hi_o;
  logic [NCH*AW-1:0] cur_addr_o;
  logic [NCH*PW-1:0] pos_o, xfer_len_o;

  dmab_chan_bank #(.NUM_CH(NCH), .WORD_MODE(0)) u_dmab_chan_bank (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_ba [NCH], m_bc [NCH], m_cur [NCH], m_pos [NCH];
  bit m_ff;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(int off, bit hi);
    int ch = off >> 1;
    logic [31:0] v;
    if (off & 1) v = (m_bc[ch] << SH) - m_pos[ch];
    else v = dir_down_i[ch] ? (m_cur[ch] - m_pos[ch]) : (m_cur[ch] + m_pos[ch]);
    return 8'(v >> (SH + (hi ? 8 : 0)));
  endfunction

  // one full cycle with any mix of stimuli; model updated after the edge
  task automatic cyc(bit wr, bit rd, int off, logic [7:0] d, bit clr, bit crst,
                     bit pwe, int pch, logic [PW-1:0] pval, string req);
    int ch = off >> 1;
    @(negedge clk);
    bus_off_i = 3'(off); wr_en_i = wr; rd_en_i = rd; wr_data_i = d;
    ff_clear_i = clr; ctl_reset_i = crst;
    pos_we_i = pwe; pos_chan_i = 2'(pch); pos_val_i = pval;
    #2;
    if (rd) check({req, " R11 read byte"}, 32'(rd_data_o), 32'(exp_rd(off, m_ff)));
    @(posedge clk);
    #1;
    wr_en_i = 0; rd_en_i = 0; ff_clear_i = 0; ctl_reset_i = 0; pos_we_i = 0;
    if (pwe) m_pos[pch] = 32'(pval);
    if (wr) begin
      if (off & 1) begin
        if (m_ff) m_bc[ch][15:8] = d; else m_bc[ch][7:0] = d;
      end else begin
        if (m_ff) m_ba[ch][15:8] = d; else m_ba[ch][7:0] = d;
      end
      if (m_ff) begin
        m_cur[ch] = m_ba[ch] << SH;
        m_pos[ch] = 0;
      end
    end
    if (clr || crst) m_ff = 0;
    else if (wr || rd) m_ff = ~m_ff;
    check({req, " R2/R3 pointer"}, 32'(byte_hi_o), 32'(m_ff));
  endtask

  task automatic wr_b(int off, logic [7:0] d, string req);
    cyc(1, 0, off, d, 0, 0, 0, 0, '0, req);
  endtask
  task automatic rd_b(int off, string req);
    cyc(0, 1, off, 8'h00, 0, 0, 0, 0, '0, req);
  endtask

  task automatic check_outs(string req);
    for (int c = 0; c < NCH; c++) begin
      check({req, " cur_addr"}, 32'(cur_addr_o[c*AW +: AW]), m_cur[c]);
      check({req, " pos"}, 32'(pos_o[c*PW +: PW]), m_pos[c]);
      check({req, " R10 xfer_len"}, 32'(xfer_len_o[c*PW +: PW]), ((m_bc[c] + 1) << SH));
    end
  endtask

  task automatic read_all(string req);
    for (int o = 0; o < 8; o++) begin
      rd_b(o, req);
      rd_b(o, req);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_off_i = 0; wr_en_i = 0; rd_en_i = 0; wr_data_i = 0;
    ff_clear_i = 0; ctl_reset_i = 0; dir_down_i = '0; pos_we_i = 0;
    pos_chan_i = 0; pos_val_i = '0;
    for (int c = 0; c < NCH; c++) begin
      m_ba[c] = 0; m_bc[c] = 0; m_cur[c] = 0; m_pos[c] = 0;
    end
    m_ff = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pointer", 32'(byte_hi_o), 0);
    check_outs("R1 reset");
    @(negedge clk) rst_n = 1;
    read_all("R1 reset read");

    // R9 R5: program every channel with distinct patterns
    for (int c = 0; c < NCH; c++) begin
      wr_b(2*c,   8'(8'h13 + 8'(c*37)), "R9 addr lo");
      wr_b(2*c,   8'(8'hA0 + 8'(c*29)), "R5 addr hi");
      wr_b(2*c+1, 8'(8'h05 + 8'(c*71)), "R9 cnt lo");
      wr_b(2*c+1, 8'(8'h40 + 8'(c*17)), "R5 cnt hi");
    end
    check_outs("R5 R10 after program");
    read_all("R6 R7 R9 readback");

    // R4: low-only writes do not restart and leave high bytes alone
    wr_b(5, 8'h5A, "R4 cnt lo only");
    cyc(0, 0, 0, 8'h00, 1, 0, 0, 0, '0, "R3 clear");
    wr_b(2, 8'hC3, "R4 addr lo only");
    cyc(0, 0, 0, 8'h00, 0, 1, 0, 0, '0, "R3 ctl reset");
    check_outs("R4 no restart");
    rd_b(5, "R4 R7 cnt after lo");
    rd_b(5, "R4 R7 cnt hi kept");
    // now restart ch1 so the low addr byte shows up
    rd_b(0, "R2 ptr to hi");
    wr_b(2, 8'h77, "R5 addr hi restart");
    check_outs("R4 R5 lo byte taken");

    // R8 R6 R7: positions in both directions, including negative remainders
    for (int c = 0; c < NCH; c++) begin
      cyc(0, 0, 0, 8'h00, 0, 0, 1, c, PW'(32'h00123 * (c + 1) + 32'hF000 * c), "R8 pos load");
    end
    check_outs("R8 pos visible");
    for (int dmask = 0; dmask < 16; dmask += 5) begin
      dir_down_i = 4'(dmask);
      read_all("R6 R7 with position");
    end
    dir_down_i = 4'b1010;
    cyc(0, 0, 0, 8'h00, 0, 0, 1, 2, 17'h1FFFF, "R8 large pos");
    read_all("R6 R7 wrap");

    // R3: clear wins over a simultaneous access
    if (!m_ff) rd_b(1, "R2 ptr to hi");
    cyc(0, 1, 3, 8'h00, 1, 0, 0, 0, '0, "R3 clear vs read");
    rd_b(1, "R2 ptr to hi");
    cyc(1, 0, 7, 8'h99, 0, 1, 0, 0, '0, "R3 ctl reset vs write");
    check_outs("R3 write still lands");

    // R8: restart on same channel beats engine write; other channel loads
    if (!m_ff) rd_b(0, "R2 ptr to hi");
    cyc(1, 0, 6, 8'h31, 0, 0, 1, 3, 17'h00456, "R8 collision same ch");
    check("R8 restart wins", 32'(pos_o[3*PW +: PW]), 0);
    if (!m_ff) rd_b(0, "R2 ptr to hi");
    cyc(1, 0, 6, 8'h32, 0, 0, 1, 0, 17'h00789, "R8 collision other ch");
    check_outs("R8 other channel");

    // R10: maximum base count
    wr_b(1, 8'hFF, "R10 cnt byte");
    wr_b(1, 8'hFF, "R10 cnt byte");
    check("R10 max length", 32'(xfer_len_o[0 +: PW]), 32'h10000);
    check_outs("R10 max");
    read_all("R7 max count");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule